// File: doc/BRIEF.md
# Packed Signed Lane Adder with Sign Flags

This unit adds two 32-bit words as packed signed integers. A mode input picks the lane layout: four independent 8-bit lanes or two independent 16-bit lanes. Each lane's operands are sign-extended by one bit and then added. The low lane-width bits of that wider sum form the lane's part of the result word, so an overflowing lane wraps and is not saturated.

Alongside the result, the unit produces a 4-bit greater-or-equal flag vector. Each flag is set when its lane's widened sum is zero or positive. In halfword mode each lane owns two adjacent flag bits and drives both of them to the same value. The flags come out on their own port and are never packed into the result word.

Inputs are sampled on a clock edge when the input strobe is high. The result and the flags appear on the registered outputs one clock later, together with an output strobe. When the input strobe is low, the outputs keep their last values.

Top module: `simd_sadd_unit`

## Requirements
- R1: With mode_i = 0, result bits [8i+7:8i] equal the low 8 bits of the signed sum of operand bits [8i+7:8i], for lanes i = 0..3 (wraps, e.g. -128 + -128 gives 0x00 and 127 + 1 gives 0x80).
- R2: With mode_i = 1, result bits [16i+15:16i] equal the low 16 bits of the signed sum of operand bits [16i+15:16i], for lanes i = 0..1 (e.g. 32767 + 1 gives 0x8000).
- R3: With mode_i = 0, ge_o bit i is 1 exactly when the 9-bit sign-extended sum of byte lane i is greater than or equal to zero.
- R4: With mode_i = 1, ge_o bits 2i and 2i+1 are both 1 when the 17-bit sign-extended sum of halfword lane i is greater than or equal to zero, and both 0 otherwise.
- R5: No carry crosses a lane boundary: an overflow in one lane leaves every other lane's result and flag unchanged.
- R6: An input sampled with valid_i high shows on result_o and ge_o after exactly one rising clock edge, with valid_o high in that cycle. valid_o is low after an edge that sampled valid_i low.
- R7: While rst_ni is low, result_o, ge_o and valid_o are all zero.
- R8: result_o and ge_o hold their values across every edge that samples valid_i low, whatever the operands and mode are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 1 | Lane layout: 0 = four 8-bit lanes, 1 = two 16-bit lanes |
| op_a_i | input | 32 | First packed operand |
| op_b_i | input | 32 | Second packed operand |
| valid_o | output | 1 | Result and flags updated on the last edge |
| result_o | output | 32 | Packed wrapped lane sums |
| ge_o | output | 4 | Per-lane non-negative sum flags |

## Verification
The assertions assume that valid_i, mode_i and both operands are stable and known around each rising edge, and that valid_i is held low for the whole of reset. The bench changes its inputs only on falling edges and keeps valid_i low while rst_ni is asserted. Its operands are either hand-picked lane extremes or words built by a fixed-step generator, so every value it drives is fully defined.

// File: rtl/simd_sadd_pkg.sv
package simd_sadd_pkg;
  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_HALF = 1'b1
  } lane_mode_e;

  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_HALF_W = 16;
endpackage

// File: rtl/simd_lane_add.sv
// One isolated signed lane: widened sum, wrapped result, sign flag.
module simd_lane_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         nonneg_o
);
  logic [W:0] wide;

  always_comb begin
    wide     = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    sum_o    = wide[W-1:0];
    nonneg_o = ~wide[W];
  end
endmodule

// File: rtl/simd_lane_mux.sv
// Picks byte or halfword lane outputs; spreads halfword flags over their byte slots.
module simd_lane_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16,
  localparam int unsigned NB    = DATA_W / BYTE_W,
  localparam int unsigned NH    = DATA_W / HALF_W,
  localparam int unsigned RATIO = HALF_W / BYTE_W
) (
  input  logic              half_i,
  input  logic [DATA_W-1:0] byte_sum_i,
  input  logic [NB-1:0]     byte_ge_i,
  input  logic [DATA_W-1:0] half_sum_i,
  input  logic [NH-1:0]     half_ge_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NB-1:0]     ge_o
);
  logic [NB-1:0] half_ge_spread;

  for (genvar j = 0; j < NB; j++) begin : g_spread
    assign half_ge_spread[j] = half_ge_i[j / RATIO];
  end

  always_comb begin
    sum_o = half_i ? half_sum_i     : byte_sum_i;
    ge_o  = half_i ? half_ge_spread : byte_ge_i;
  end
endmodule

// File: rtl/simd_sadd_unit.sv
module simd_sadd_unit
  import simd_sadd_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned NB    = DATA_W / BYTE_W,
  localparam int unsigned NH    = DATA_W / HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [NB-1:0]     ge_o
);
  logic [DATA_W-1:0] byte_sum, half_sum, sel_sum;
  logic [NB-1:0]     byte_ge, sel_ge;
  logic [NH-1:0]     half_ge;
  lane_mode_e        mode;

  assign mode = lane_mode_e'(mode_i);

  // Both layouts are built side by side; mode only steers the output mux.
  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane_add #(.W(BYTE_W)) u_lane (
      .a_i      (op_a_i[i*BYTE_W +: BYTE_W]),
      .b_i      (op_b_i[i*BYTE_W +: BYTE_W]),
      .sum_o    (byte_sum[i*BYTE_W +: BYTE_W]),
      .nonneg_o (byte_ge[i])
    );
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_lane_add #(.W(HALF_W)) u_lane (
      .a_i      (op_a_i[i*HALF_W +: HALF_W]),
      .b_i      (op_b_i[i*HALF_W +: HALF_W]),
      .sum_o    (half_sum[i*HALF_W +: HALF_W]),
      .nonneg_o (half_ge[i])
    );
  end

  simd_lane_mux #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .HALF_W (HALF_W)
  ) u_mux (
    .half_i     (mode == MODE_HALF),
    .byte_sum_i (byte_sum),
    .byte_ge_i  (byte_ge),
    .half_sum_i (half_sum),
    .half_ge_i  (half_ge),
    .sum_o      (sel_sum),
    .ge_o       (sel_ge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      ge_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= sel_sum;
        ge_o     <= sel_ge;
      end
    end
  end
endmodule

// File: rtl/simd_sadd_chk.sv
module simd_sadd_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16,
  localparam int unsigned NB    = DATA_W / BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic [NB-1:0]     ge_o
);
  logic [BYTE_W:0] b0_wide, b1_wide;
  logic [HALF_W:0] h0_wide;

  assign b0_wide = {op_a_i[BYTE_W-1], op_a_i[BYTE_W-1:0]}
                 + {op_b_i[BYTE_W-1], op_b_i[BYTE_W-1:0]};
  assign b1_wide = {op_a_i[2*BYTE_W-1], op_a_i[2*BYTE_W-1:BYTE_W]}
                 + {op_b_i[2*BYTE_W-1], op_b_i[2*BYTE_W-1:BYTE_W]};
  assign h0_wide = {op_a_i[HALF_W-1], op_a_i[HALF_W-1:0]}
                 + {op_b_i[HALF_W-1], op_b_i[HALF_W-1:0]};

  AST_BYTE0_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i |=> result_o[BYTE_W-1:0] == $past(b0_wide[BYTE_W-1:0])); // R1
  AST_HALF0_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i |=> result_o[HALF_W-1:0] == $past(h0_wide[HALF_W-1:0])); // R2
  AST_BYTE0_GE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i |=> ge_o[0] == !$past(b0_wide[BYTE_W])); // R3
  AST_HALF_GE_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mode_i |=> (ge_o[0] == ge_o[1]) && (ge_o[2] == ge_o[3])); // R4
  AST_LANE1_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_i |=> result_o[2*BYTE_W-1:BYTE_W] == $past(b1_wide[BYTE_W-1:0])
                           && ge_o[1] == !$past(b1_wide[BYTE_W])); // R5
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(ge_o)); // R8
endmodule

bind simd_sadd_unit simd_sadd_chk #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .HALF_W (HALF_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .op_a_i   (op_a_i),
  .op_b_i   (op_b_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .ge_o     (ge_o)
);

// File: tb/simd_sadd_unit_tb.sv
`timescale 1ns/1ps
module simd_sadd_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  ge_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_sadd_unit u_dut (
    .clk_i, .rst_ni, .valid_i, .mode_i, .op_a_i, .op_b_i,
    .valid_o, .result_o, .ge_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Model built from the requirements: sign-extend, add, wrap, flag on sign.
  task automatic ref_calc(input logic m, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic [3:0] g);
    r = '0;
    g = '0;
    if (!m) begin
      for (int i = 0; i < 4; i++) begin
        logic [8:0] s;
        s = {a[8*i+7], a[8*i +: 8]} + {b[8*i+7], b[8*i +: 8]};
        r[8*i +: 8] = s[7:0];
        g[i] = ~s[8];
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [16:0] s;
        s = {a[16*i+15], a[16*i +: 16]} + {b[16*i+15], b[16*i +: 16]};
        r[16*i +: 16] = s[15:0];
        g[2*i] = ~s[16];
        g[2*i+1] = ~s[16];
      end
    end
  endtask

  task automatic apply(input string req, input logic m, input logic [31:0] a,
                       input logic [31:0] b);
    logic [31:0] er;
    logic [3:0]  eg;
    ref_calc(m, a, b, er, eg);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " result"}, result_o, er);
    check({req, " ge"}, {28'd0, ge_o}, {28'd0, eg});
    check("R6 valid_o", {31'd0, valid_o}, 32'd1);
  endtask

  task automatic t_reset();
    check("R7 reset result", result_o, 32'd0);
    check("R7 reset ge", {28'd0, ge_o}, 32'd0);
    check("R7 reset valid", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_byte_corners();
    apply("R1/R3 -128+-128", 1'b0, 32'h0000_0080, 32'h0000_0080);
    apply("R1/R3 127+1",     1'b0, 32'h0000_007F, 32'h0000_0001);
    apply("R1/R3 mixed",     1'b0, 32'h7F80_FF01, 32'h0180_01FF);
    apply("R1/R3 -1+0",      1'b0, 32'hFFFF_FFFF, 32'h0000_0000);
  endtask

  task automatic t_half_corners();
    apply("R2/R4 -32768+-32768", 1'b1, 32'h0000_8000, 32'h0000_8000);
    apply("R2/R4 32767+1",       1'b1, 32'h7FFF_7FFF, 32'h0001_0001);
    apply("R2/R4 mixed",         1'b1, 32'h8000_00FF, 32'hFFFF_0001);
  endtask

  // Byte overflow in each lane next to quiet neighbours.
  task automatic t_isolation();
    apply("R5 lane0 ovf",  1'b0, 32'h0101_01FF, 32'h0101_0101);
    apply("R5 lane1 ovf",  1'b0, 32'h0000_7F00, 32'h0000_0100);
    apply("R5 lane2 ovf",  1'b0, 32'h0080_0000, 32'h0080_0000);
    apply("R5 half0 ovf",  1'b1, 32'h0000_FFFF, 32'h0000_0001);
  endtask

  task automatic t_hold();
    logic [31:0] er;
    logic [3:0]  eg;
    ref_calc(1'b0, 32'h1234_5678, 32'h1111_1111, er, eg);
    apply("R8 setup", 1'b0, 32'h1234_5678, 32'h1111_1111);
    @(negedge clk_i);
    mode_i = 1'b1; op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h8080_8080;
    repeat (3) @(negedge clk_i);
    check("R8 hold result", result_o, er);
    check("R8 hold ge", {28'd0, ge_o}, {28'd0, eg});
    check("R6 idle valid_o", {31'd0, valid_o}, 32'd0);
  endtask

  task automatic t_sweep();
    logic [31:0] a = 32'h1357_9BDF;
    logic [31:0] b = 32'hFEDC_BA98;
    for (int k = 0; k < 40; k++) begin
      a = a * 32'd1103515245 + 32'd12345;
      b = b * 32'd69069 + 32'd1;
      apply((k % 2) ? "R2/R4 sweep" : "R1/R3 sweep", k[0], a, b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_byte_corners();
    t_half_corners();
    t_isolation();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule